// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block watches eight asynchronous input signals and turns them into up to eight sum-of-products match outputs. It has eight bit slices arranged in a chain. Each slice routes one chosen input through its own 3-bit selector and tests it against a condition: constant true or false, high or low level, a sticky rising, falling or either-edge flag, or a single-cycle event. Neighbouring slices are ANDed together. A slice flagged as an endpoint closes the product term that runs back to the slice after the previous endpoint. That term then drives the match output with the endpoint's index. The last slice always closes a term.

Software configures the engine through a simple synchronous register bus. Writes take effect on the clock edge. Reads return data combinationally from the addressed register. A control register decides whether the match outputs follow the engine or stay low, and enables an event output. That output pulses for one cycle each time the OR of all terms rises. The same register also reads back the live state of every term. Sticky edge flags are cleared only by writing the source register or the condition register.

Top module: `pmatch_engine`

## Requirements
- R1: After reset, every register reads zero except the live term bits, `match_out` is 0 and `event_out` is 0. With the reset configuration every slice is constant-true, so the control register reads 0x8000_0000.
- R2: The source register sits at offset 0x2C. Slice k's input selector occupies bits [8+3k+2 : 8+3k] and picks input 0 to 7.
- R3: The condition register sits at offset 0x30. Slice k's 3-bit condition is at bits [8+3k+2 : 8+3k]. Codes 0, 4, 5 and 6 mean always true, selected input high, selected input low and never true.
- R4: Codes 1, 2 and 3 mean a rising, falling, or either edge has been seen on the selected input. The flag stays set until the source or condition register is written, and such a write clears it.
- R5: Code 7 is true for exactly one clock cycle when an edge of either polarity is detected on the selected input.
- R6: Bits 0 to 6 of the condition register mark slices 0 to 6 as endpoints, and slice 7 is always an endpoint. Term n is the AND of the slices from the one after the previous endpoint through slice n, and it drives `match_out[n]`. Non-endpoint outputs stay 0.
- R7: Control register (offset 0x28) bit 0 set to 1 lets the engine drive `match_out`. Set to 0, it forces `match_out` to 0.
- R8: With control bit 1 set, `event_out` is high for one cycle after each 0-to-1 transition of the OR of all terms. With bit 1 clear it stays 0.
- R9: Control bits 31:24 read the current term state (bit 24+n is term n) and ignore writes.
- R10: Inputs pass two synchronizer flops. A level change applied before clock edge E0 shows on `match_out` after edge E2 and not after E1. A register write at edge W shows on `match_out` after edge W+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sig_in | input | 8 | Asynchronous input signals |
| match_out | output | 8 | Per-term match outputs |
| event_out | output | 1 | Single-cycle pulse on rise of any term |

## Verification
The embedded assertions check several properties on every cycle. Sticky flags hold until a source or condition write and drop on that write. `match_out` stays low whenever the control select bit was clear. A match bit only rises on a slice that was an endpoint. `event_out` never lasts two cycles. Other behaviours can only be shown by the directed scenarios: the meaning of each condition code, the selector and field bit positions, how the chain splits into terms at endpoints, the exact synchronizer latency, and whether the live term bits ignore writes.

// File: rtl/pm_pkg.sv
// Package: shared constants and types for the pattern match engine.
// Assumes a 32-bit register bus and eight slices with 3-bit fields.
package pm_pkg;
    localparam int N_SLICE  = 8;
    localparam int SEL_W    = $clog2(N_SLICE);
    localparam int COND_W   = 3;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int FIELD_LO = 8;   // first per-slice field bit
    localparam int TERM_LO  = DATA_W - N_SLICE;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_COND = 8'h30;

    typedef enum logic [COND_W-1:0] {
        C_ONE   = 3'd0,
        C_RISE  = 3'd1,
        C_FALL  = 3'd2,
        C_EDGE  = 3'd3,
        C_HIGH  = 3'd4,
        C_LOW   = 3'd5,
        C_ZERO  = 3'd6,
        C_EVENT = 3'd7
    } cond_e;
endpackage

// File: rtl/pm_sync.sv
// Module: pm_sync
// Synchronizes a bus of asynchronous inputs through STAGES flops and
// derives single-cycle rise and fall strobes from the synchronized level.
// Assumes STAGES >= 1; reset is synchronous and active low.
module pm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] pipe_q;
    logic [W-1:0]             prev_q;

    // First synchronizer stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= din;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Further stages shift the sampled value down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    endgenerate

    // Keeps the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pipe_q[STAGES-1];
    end

    assign level = pipe_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/pm_slice.sv
// Module: pm_slice
// One bit slice: selects an input, keeps sticky edge flags for it and
// evaluates the configured condition into a single hit bit.
// Assumes clr pulses on any write to the source or condition register.
module pm_slice
    import pm_pkg::*;
#(
    parameter int NIN = N_SLICE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic [$clog2(NIN)-1:0]   src,
    input  cond_e                    cond,
    input  logic [NIN-1:0]           level,
    input  logic [NIN-1:0]           rise,
    input  logic [NIN-1:0]           fall,
    output logic                     hit
);
    logic lvl, r_now, f_now;
    logic rise_seen_q, fall_seen_q;

    assign lvl   = level[src];
    assign r_now = rise[src];
    assign f_now = fall[src];

    // Sticky edge flags: set by edges, cleared only by a config write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rise_seen_q <= 1'b0;
            fall_seen_q <= 1'b0;
        end else begin
            if (r_now) rise_seen_q <= 1'b1;
            if (f_now) fall_seen_q <= 1'b1;
        end
    end

    // Condition decode for this slice.
    always_comb begin
        unique case (cond)
            C_ONE:   hit = 1'b1;
            C_RISE:  hit = rise_seen_q | r_now;
            C_FALL:  hit = fall_seen_q | f_now;
            C_EDGE:  hit = rise_seen_q | fall_seen_q | r_now | f_now;
            C_HIGH:  hit = lvl;
            C_LOW:   hit = ~lvl;
            C_ZERO:  hit = 1'b0;
            C_EVENT: hit = r_now | f_now;
            default: hit = 1'b0;
        endcase
    end

    // R4: a set flag survives every cycle without a config write.
    a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_seen_q || fall_seen_q) && !clr) |=>
            (rise_seen_q || fall_seen_q));

    // R4: a config write leaves both flags clear.
    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rise_seen_q && !fall_seen_q));
endmodule

// File: rtl/pm_regs.sv
// Module: pm_regs
// Register file: control, source and condition registers with a
// combinational read path. Generates the sticky-clear strobe.
// Assumes full-address decode; unmapped offsets read as zero.
module pm_regs
    import pm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [N_SLICE-1:0]                term,
    output logic                              sel_pm,
    output logic                              ev_en,
    output logic [N_SLICE-1:0][SEL_W-1:0]     src_sel,
    output logic [N_SLICE-1:0][COND_W-1:0]    cond_sel,
    output logic [N_SLICE-1:0]                endpoint,
    output logic                              clr
);
    localparam int FIELDS_W = N_SLICE * SEL_W;

    logic                  sel_q, ev_q;
    logic [FIELDS_W-1:0]   src_q, cond_q;
    logic [N_SLICE-2:0]    ep_q;
    logic                  unused_wbit;

    assign unused_wbit = bus_wdata[N_SLICE-1];

    // Control bits; the live term bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            ev_q  <= 1'b0;
        end else if (bus_wr && bus_addr == OFS_CTRL) begin
            sel_q <= bus_wdata[0];
            ev_q  <= bus_wdata[1];
        end
    end

    // Source selector fields.
    always_ff @(posedge clk) begin
        if (!rst_n)                                src_q <= '0;
        else if (bus_wr && bus_addr == OFS_SRC)    src_q <= bus_wdata[FIELD_LO +: FIELDS_W];
    end

    // Condition fields and endpoint flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= '0;
            ep_q   <= '0;
        end else if (bus_wr && bus_addr == OFS_COND) begin
            cond_q <= bus_wdata[FIELD_LO +: FIELDS_W];
            ep_q   <= bus_wdata[N_SLICE-2:0];
        end
    end

    genvar k;
    generate
        for (k = 0; k < N_SLICE; k++) begin : g_field
            assign src_sel[k]  = src_q[k*SEL_W +: SEL_W];
            assign cond_sel[k] = cond_q[k*COND_W +: COND_W];
        end
    endgenerate

    assign endpoint = {1'b1, ep_q};
    assign sel_pm   = sel_q;
    assign ev_en    = ev_q;
    assign clr      = bus_wr && (bus_addr == OFS_SRC || bus_addr == OFS_COND);

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = {term, {(TERM_LO-2){1'b0}}, ev_q, sel_q};
            OFS_SRC:  bus_rdata = {src_q, {FIELD_LO{1'b0}}};
            OFS_COND: bus_rdata = {cond_q, 1'b0, ep_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmatch_engine.sv
// Module: pmatch_engine (top)
// Chains eight bit slices into product terms split at endpoint flags,
// registers the per-term outputs and the combined event pulse.
// Assumes sig_in is asynchronous; all state resets synchronously to zero.
module pmatch_engine
    import pm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [N_SLICE-1:0]   sig_in,
    output logic [N_SLICE-1:0]   match_out,
    output logic                 event_out
);
    logic [N_SLICE-1:0]              lvl, rise, fall, hit, run, term, ep;
    logic [N_SLICE-1:0][SEL_W-1:0]   src_sel;
    logic [N_SLICE-1:0][COND_W-1:0]  cond_sel;
    logic                            sel_pm, ev_en, clr, any_q, ev_q;
    logic [N_SLICE-1:0]              match_q;

    pm_sync #(.W(N_SLICE), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sig_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    pm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .term(term),
        .sel_pm(sel_pm), .ev_en(ev_en), .src_sel(src_sel),
        .cond_sel(cond_sel), .endpoint(ep), .clr(clr)
    );

    genvar k;
    generate
        for (k = 0; k < N_SLICE; k++) begin : g_slice
            pm_slice #(.NIN(N_SLICE)) u_slice (
                .clk(clk), .rst_n(rst_n), .clr(clr),
                .src(src_sel[k]), .cond(cond_e'(cond_sel[k])),
                .level(lvl), .rise(rise), .fall(fall), .hit(hit[k])
            );
        end
    endgenerate

    // AND chain that restarts after every endpoint.
    always_comb begin
        for (int i = 0; i < N_SLICE; i++) begin
            if (i == 0) run[i] = hit[i];
            else        run[i] = hit[i] & (ep[i-1] | run[i-1]);
        end
        term = run & ep;
    end

    // Output register: engine terms or forced low.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= sel_pm ? term : '0;
    end

    // Event pulse on each rise of the OR of all terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            ev_q  <= 1'b0;
        end else begin
            any_q <= |term;
            ev_q  <= ev_en & (|term) & ~any_q;
        end
    end

    assign match_out = match_q;
    assign event_out = ev_q;

    // R7: deselected engine leaves the outputs low on the next cycle.
    a_r7_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_pm |=> (match_out == '0));

    // R8: the event output never stays high two cycles running.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        event_out |=> !event_out);

    generate
        for (k = 0; k < N_SLICE - 1; k++) begin : g_ep_chk
            // R6: a match bit needs its slice to have been an endpoint.
            a_r6_endpoint_only: assert property (@(posedge clk)
                disable iff (!rst_n)
                match_out[k] |-> $past(ep[k]));
        end
    endgenerate
endmodule

// File: tb/pmatch_engine_bench.sv
// Directed bench for pmatch_engine; one task per scenario.
module pmatch_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  sig_in = '0;
    logic [7:0]  match_out;
    logic        event_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h28, A_SRC = 8'h2C, A_COND = 8'h30;

    pmatch_engine u_pmatch_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sig_in(sig_in),
        .match_out(match_out), .event_out(event_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        sig_in = v;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] fld(input int k, input int v);
        return 32'(v) << (8 + 3 * k);
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 match_out", {24'b0, match_out}, 32'h0);
        chk("R1 event_out", {31'b0, event_out}, 32'h0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h8000_0000);
        rd(A_SRC, d);  chk("R1 src", d, 32'h0);
        rd(A_COND, d); chk("R1 cond", d, 32'h0);
    endtask

    task automatic t_live_bits;
        logic [31:0] d;
        wr(A_CTRL, 32'hFF00_0001);
        rd(A_CTRL, d); chk("R9 live bits ignore writes", d, 32'h8000_0001);
        wait_n(1);
        chk("R6 slice7 default endpoint", {24'b0, match_out}, 32'h80);
    endtask

    task automatic t_level;
        // slice0 HIGH on input 5, endpoint 0, slice7 never
        wr(A_SRC, fld(0, 5));
        wr(A_COND, 32'h1 | fld(0, 4) | fld(7, 6));
        wait_n(1);
        chk("R3 high idle", {24'b0, match_out}, 32'h0);
        drive(8'h20);
        wait_n(2);
        chk("R10 not after E1", {24'b0, match_out}, 32'h0);
        wait_n(1);
        chk("R2 R3 high on input5", {24'b0, match_out}, 32'h01);
        drive(8'h1F); wait_n(3);
        chk("R2 other inputs ignored", {24'b0, match_out}, 32'h0);
        wr(A_COND, 32'h1 | fld(0, 5) | fld(7, 6));
        wait_n(1);
        chk("R3 low", {24'b0, match_out}, 32'h01);
        // slice3 on input 2, endpoint 3; slices 0..2 constant true
        wr(A_SRC, fld(3, 2));
        wr(A_COND, 32'h8 | fld(3, 4) | fld(7, 6));
        drive(8'h04); wait_n(3);
        chk("R2 slice3 field", {24'b0, match_out}, 32'h08);
        drive(8'h08); wait_n(3);
        chk("R2 slice3 deselected", {24'b0, match_out}, 32'h0);
        wr(A_COND, 32'h1 | fld(0, 6) | fld(7, 6));
        wait_n(1);
        chk("R3 never", {24'b0, match_out}, 32'h0);
    endtask

    task automatic t_chain;
        logic [31:0] s, c, d;
        s = '0; c = 32'h12;
        for (int k = 0; k < 8; k++) begin
            s |= fld(k, k);
            c |= fld(k, 4);
        end
        wr(A_SRC, s);
        wr(A_COND, c);
        drive(8'h03); wait_n(3);
        chk("R6 term1", {24'b0, match_out}, 32'h02);
        drive(8'h1C); wait_n(3);
        chk("R6 term4", {24'b0, match_out}, 32'h10);
        drive(8'hE0); wait_n(3);
        chk("R6 term7", {24'b0, match_out}, 32'h80);
        drive(8'h0D); wait_n(3);
        chk("R6 partial terms", {24'b0, match_out}, 32'h0);
        drive(8'hFF); wait_n(3);
        chk("R6 all terms", {24'b0, match_out}, 32'h92);
        rd(A_CTRL, d); chk("R9 live term read", d, 32'h9200_0001);
        drive(8'h00); wait_n(3);
    endtask

    task automatic t_sticky;
        wr(A_SRC, 32'h0);
        wr(A_COND, 32'h1 | fld(0, 1) | fld(7, 6));
        drive(8'h01); wait_n(3);
        chk("R4 rise seen", {24'b0, match_out}, 32'h01);
        drive(8'h00); wait_n(3);
        chk("R4 rise sticky", {24'b0, match_out}, 32'h01);
        wr(A_SRC, 32'h0); wait_n(1);
        chk("R4 src write clears", {24'b0, match_out}, 32'h0);
        wr(A_COND, 32'h1 | fld(0, 2) | fld(7, 6));
        drive(8'h01); wait_n(3);
        chk("R4 fall ignores rise", {24'b0, match_out}, 32'h0);
        drive(8'h00); wait_n(3);
        chk("R4 fall seen", {24'b0, match_out}, 32'h01);
        wr(A_COND, 32'h1 | fld(0, 3) | fld(7, 6)); wait_n(1);
        chk("R4 cond write clears", {24'b0, match_out}, 32'h0);
        drive(8'h01); wait_n(3);
        chk("R4 either edge", {24'b0, match_out}, 32'h01);
    endtask

    task automatic t_event;
        wr(A_COND, 32'h1 | fld(0, 7) | fld(7, 6));
        wait_n(1);
        chk("R5 idle", {24'b0, match_out}, 32'h0);
        drive(8'h00); wait_n(3);
        chk("R5 event cycle", {24'b0, match_out}, 32'h01);
        wait_n(1);
        chk("R5 event gone", {24'b0, match_out}, 32'h0);
    endtask

    task automatic t_outputs;
        wr(A_COND, 32'h1 | fld(0, 4) | fld(7, 6));
        wr(A_CTRL, 32'h3);
        drive(8'h01); wait_n(3);
        chk("R8 pulse high", {31'b0, event_out}, 32'h1);
        chk("R8 match with pulse", {24'b0, match_out}, 32'h01);
        wait_n(1);
        chk("R8 pulse ends", {31'b0, event_out}, 32'h0);
        wr(A_CTRL, 32'h0); wait_n(1);
        chk("R7 forced low", {24'b0, match_out}, 32'h0);
        wr(A_CTRL, 32'h1); wait_n(1);
        chk("R7 reselected", {24'b0, match_out}, 32'h01);
        drive(8'h00); wait_n(3);
        drive(8'h01); wait_n(3);
        chk("R8 disabled no pulse", {31'b0, event_out}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_live_bits();
        t_level();
        t_chain();
        t_sticky();
        t_event();
        t_outputs();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule